// File: doc/BRIEF.md
# AUX Request Header Formatter

This block sits between a requester that issues display-link auxiliary-channel transactions and a channel engine that moves bytes over the wire. It takes one request, made of a 20-bit address, a 4-bit request code and a payload length, and checks it. It then emits a four-byte header on an outbound byte stream. For a write, the payload bytes follow the header, passed straight through from the requester's payload stream.

After the engine answers with a reply status and a reply length, the block forwards any read bytes to the requester, clamped to the length the requester asked for. It then presents a completion record that holds an error code, a byte count and the reply code.

The controller is a single state machine with six states. IDLE accepts a request. HDR sends the header bytes. PAY forwards the payload. WAIT expects the reply header. DATA drains the reply bytes. DONE holds the completion record. The transitions are:
- IDLE→DONE when the request is rejected.
- IDLE→HDR when the request is accepted.
- HDR→PAY for a write with a payload.
- HDR→WAIT for a read or a bare-address write.
- PAY→WAIT after the last payload byte.
- WAIT→DATA when the reply has a nonzero length.
- WAIT→DONE when the reply is empty.
- DATA→DONE after the last reply byte.
- DONE→IDLE when the completion is taken.

Top module: `aux_req_framer`

## Requirements
- R1: Header byte 0 is address bits 7:0 and byte 1 is address bits 15:8. Byte 2 carries the full 4-bit request code in bits 7:4 and address bits 19:16 in bits 3:0.
- R2: Bits 3:0 of header byte 3 are the length minus one, or 0 when the length is zero.
- R3: Bits 7:4 of header byte 3 are 3 when the length is zero. Otherwise they are the low four bits of (4 + length) for a write and 4 for a read.
- R4: A write sends the 4 header bytes and then its payload bytes in order. A read, or any zero-length request, sends only the 4 header bytes. tx_last marks the final byte, and a byte is held stable until tx_ready is high.
- R5: A request longer than 16 bytes completes with error code 1 (size), count 0 and reply 0. Nothing is sent. This check wins over the code check.
- R6: The request code is classified with bit 2 (the middle-of-transaction flag) masked off. Masked values 8 (native write), 9 (native read), 0 (I2C write) and 1 (I2C read) are legal, and bit 0 set means read. Any other code completes with error code 2 (invalid) and nothing is sent.
- R7: Reply status 1, 2 and 3 complete with error codes 3 (timeout), 4 (flags not zero) and 5 (link error). Count and reply are 0, and no reply byte is forwarded.
- R8: A successful read forwards, in order, the first min(reply length, request length) reply bytes on rd_valid/rd_data, and reports that number as its count. Error code 0 means success.
- R9: A successful write reports the request length as its count and forwards no bytes.
- R10: On success the reply code is bits 7:4 of the reply status.
- R11: After reset req_ready is high and no stream or completion is valid. Only one request is outstanding: req_ready stays low from acceptance until the completion record has been consumed, and that record is held stable while cpl_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 20 | Request address |
| req_cmd | input | 4 | Request code |
| req_len | input | 5 | Payload length, 0 to 31 |
| pay_valid | input | 1 | Payload byte offered |
| pay_ready | output | 1 | Payload byte taken |
| pay_data | input | 8 | Payload byte |
| tx_valid | output | 1 | Outbound byte valid |
| tx_ready | input | 1 | Engine takes outbound byte |
| tx_data | output | 8 | Outbound byte |
| tx_last | output | 1 | Final outbound byte of the request |
| rx_hdr_valid | input | 1 | Reply status and length valid |
| rx_status | input | 8 | Reply acknowledge status |
| rx_count | input | 5 | Number of reply bytes to follow |
| rx_valid | input | 1 | Reply byte valid |
| rx_data | input | 8 | Reply byte |
| rd_valid | output | 1 | Read byte forwarded to requester |
| rd_data | output | 8 | Forwarded read byte |
| cpl_valid | output | 1 | Completion record valid |
| cpl_ready | input | 1 | Requester takes completion |
| cpl_err | output | 3 | Error code |
| cpl_count | output | 5 | Byte count |
| cpl_reply | output | 4 | Reply code |

## Verification
Two functions can meet in the same cycle: a completion that is still waiting to be consumed, and the next request being offered. The bench holds cpl_ready low after a request finishes and then raises req_valid for a second request. For several cycles it checks that req_ready stays low and the record stays valid. The bench then releases cpl_ready. The scoreboard judges the outcome by requiring both completions in order, with the second request's header appearing only after the first record was consumed.

// File: rtl/aux_fmt_pkg.sv
package aux_fmt_pkg;

    localparam int HDR_BYTES = 4;

    typedef enum logic [2:0] {
        CPL_OK      = 3'd0,
        CPL_SIZE    = 3'd1,
        CPL_INVAL   = 3'd2,
        CPL_TIMEOUT = 3'd3,
        CPL_FLAGS   = 3'd4,
        CPL_LINK    = 3'd5
    } cpl_code_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_PAY,
        ST_WAIT,
        ST_DATA,
        ST_DONE
    } fsm_e;

endpackage

// File: rtl/aux_hdr_build.sv
module aux_hdr_build #(
    parameter int MAX_PAY = 16,
    parameter int LEN_W   = 5
) (
    input  logic [19:0]      addr,
    input  logic [3:0]       cmd,
    input  logic [LEN_W-1:0] len,
    output logic [3:0][7:0]  hdr,
    output logic             is_wr,
    output logic             cmd_ok,
    output logic             len_ok
);
    logic [3:0] base;
    logic [3:0] lo_nib;
    logic [3:0] hi_nib;
    logic       zero_len;

    assign base     = cmd & 4'b1011;
    assign cmd_ok   = (base == 4'h0) || (base == 4'h1) || (base == 4'h8) || (base == 4'h9);
    assign is_wr    = ~cmd[0];
    assign len_ok   = (len <= LEN_W'(MAX_PAY));
    assign zero_len = (len == '0);

    always_comb begin
        lo_nib = zero_len ? 4'd0 : (len[3:0] - 4'd1);
        if (zero_len)   hi_nib = 4'd3;
        else if (is_wr) hi_nib = len[3:0] + 4'd4;
        else            hi_nib = 4'd4;
    end

    assign hdr[0] = addr[7:0];
    assign hdr[1] = addr[15:8];
    assign hdr[2] = {cmd, addr[19:16]};
    assign hdr[3] = {hi_nib, lo_nib};

endmodule

// File: rtl/aux_reply_eval.sv
module aux_reply_eval
    import aux_fmt_pkg::*;
#(
    parameter int LEN_W = 5
) (
    input  logic [7:0]       status,
    input  logic [LEN_W-1:0] rx_cnt,
    input  logic [LEN_W-1:0] req_len,
    input  logic             is_wr,
    output cpl_code_e        code,
    output logic [LEN_W-1:0] count,
    output logic [3:0]       reply
);
    always_comb begin
        unique case (status)
            8'd1:    code = CPL_TIMEOUT;
            8'd2:    code = CPL_FLAGS;
            8'd3:    code = CPL_LINK;
            default: code = CPL_OK;
        endcase
        if (code != CPL_OK) begin
            count = '0;
            reply = 4'd0;
        end else begin
            reply = status[7:4];
            if (is_wr)                count = req_len;
            else if (rx_cnt < req_len) count = rx_cnt;
            else                       count = req_len;
        end
    end

endmodule

// File: rtl/aux_req_framer.sv
module aux_req_framer
    import aux_fmt_pkg::*;
#(
    parameter int MAX_PAY = 16,
    parameter int LEN_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [19:0]      req_addr,
    input  logic [3:0]       req_cmd,
    input  logic [LEN_W-1:0] req_len,
    input  logic             pay_valid,
    output logic             pay_ready,
    input  logic [7:0]       pay_data,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic [7:0]       tx_data,
    output logic             tx_last,
    input  logic             rx_hdr_valid,
    input  logic [7:0]       rx_status,
    input  logic [LEN_W-1:0] rx_count,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             cpl_valid,
    input  logic             cpl_ready,
    output logic [2:0]       cpl_err,
    output logic [LEN_W-1:0] cpl_count,
    output logic [3:0]       cpl_reply
);
    localparam logic [LEN_W-1:0] LAST_HDR = LEN_W'(HDR_BYTES - 1);
    localparam logic [LEN_W-1:0] ONE      = LEN_W'(1);

    fsm_e             state, state_nx;
    logic [19:0]      r_addr;
    logic [3:0]       r_cmd;
    logic [LEN_W-1:0] r_len, r_rxcnt, r_count, cnt;
    logic             r_wr;
    cpl_code_e        r_code;
    logic [3:0]       r_reply;

    logic [19:0]      b_addr;
    logic [3:0]       b_cmd;
    logic [LEN_W-1:0] b_len;
    logic [3:0][7:0]  hdr;
    logic             b_wr, b_cmd_ok, b_len_ok;

    cpl_code_e        e_code;
    logic [LEN_W-1:0] e_count;
    logic [3:0]       e_reply;

    logic             has_pay;

    // builder sees the live request while idle, the latched one afterwards
    assign b_addr  = (state == ST_IDLE) ? req_addr : r_addr;
    assign b_cmd   = (state == ST_IDLE) ? req_cmd  : r_cmd;
    assign b_len   = (state == ST_IDLE) ? req_len  : r_len;
    assign has_pay = r_wr && (r_len != '0);

    aux_hdr_build #(.MAX_PAY(MAX_PAY), .LEN_W(LEN_W)) u_hdr (
        .addr   (b_addr),
        .cmd    (b_cmd),
        .len    (b_len),
        .hdr    (hdr),
        .is_wr  (b_wr),
        .cmd_ok (b_cmd_ok),
        .len_ok (b_len_ok)
    );

    aux_reply_eval #(.LEN_W(LEN_W)) u_eval (
        .status  (rx_status),
        .rx_cnt  (rx_count),
        .req_len (r_len),
        .is_wr   (r_wr),
        .code    (e_code),
        .count   (e_count),
        .reply   (e_reply)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid)
                         state_nx = (!b_len_ok || !b_cmd_ok) ? ST_DONE : ST_HDR;
            ST_HDR:  if (tx_ready && cnt == LAST_HDR)
                         state_nx = has_pay ? ST_PAY : ST_WAIT;
            ST_PAY:  if (pay_valid && tx_ready && cnt == r_len - ONE)
                         state_nx = ST_WAIT;
            ST_WAIT: if (rx_hdr_valid)
                         state_nx = (rx_count == '0) ? ST_DONE : ST_DATA;
            ST_DATA: if (rx_valid && cnt == r_rxcnt - ONE)
                         state_nx = ST_DONE;
            ST_DONE: if (cpl_ready)
                         state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_addr  <= '0;
            r_cmd   <= '0;
            r_len   <= '0;
            r_wr    <= 1'b0;
            r_rxcnt <= '0;
            r_count <= '0;
            r_reply <= '0;
            r_code  <= CPL_OK;
            cnt     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    r_addr  <= req_addr;
                    r_cmd   <= req_cmd;
                    r_len   <= req_len;
                    r_wr    <= b_wr;
                    cnt     <= '0;
                    r_count <= '0;
                    r_reply <= '0;
                    if (!b_len_ok)      r_code <= CPL_SIZE;
                    else if (!b_cmd_ok) r_code <= CPL_INVAL;
                    else                r_code <= CPL_OK;
                end
                ST_HDR:  if (tx_ready) cnt <= (cnt == LAST_HDR) ? '0 : cnt + ONE;
                ST_PAY:  if (pay_valid && tx_ready) cnt <= cnt + ONE;
                ST_WAIT: if (rx_hdr_valid) begin
                    r_code  <= e_code;
                    r_count <= e_count;
                    r_reply <= e_reply;
                    r_rxcnt <= rx_count;
                    cnt     <= '0;
                end
                ST_DATA: if (rx_valid) cnt <= cnt + ONE;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        pay_ready = 1'b0;
        tx_valid  = 1'b0;
        tx_last   = 1'b0;
        tx_data   = pay_data;
        rd_valid  = 1'b0;
        cpl_valid = 1'b0;
        unique case (state)
            ST_IDLE: req_ready = 1'b1;
            ST_HDR: begin
                tx_valid = 1'b1;
                tx_data  = hdr[cnt[1:0]];
                tx_last  = (cnt == LAST_HDR) && !has_pay;
            end
            ST_PAY: begin
                tx_valid  = pay_valid;
                pay_ready = tx_ready;
                tx_last   = (cnt == r_len - ONE);
            end
            ST_WAIT: ;
            ST_DATA: rd_valid = rx_valid && (r_code == CPL_OK) && !r_wr && (cnt < r_count);
            ST_DONE: cpl_valid = 1'b1;
            default: ;
        endcase
    end

    assign rd_data   = rx_data;
    assign cpl_err   = r_code;
    assign cpl_count = r_count;
    assign cpl_reply = r_reply;

endmodule

// File: rtl/aux_req_framer_chk.sv
module aux_req_framer_chk
    import aux_fmt_pkg::*;
#(
    parameter int MAX_PAY = 16,
    parameter int LEN_W   = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [19:0]      req_addr,
    input logic [3:0]       req_cmd,
    input logic [LEN_W-1:0] req_len,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic [7:0]       tx_data,
    input logic             rd_valid,
    input logic             cpl_valid,
    input logic             cpl_ready,
    input logic [2:0]       cpl_err,
    input logic [LEN_W-1:0] cpl_count,
    input logic [3:0]       cpl_reply
);
    logic [LEN_W:0]   tx_seen;
    logic [LEN_W:0]   rd_seen;
    logic             lat_rd;
    logic [LEN_W-1:0] lat_len;
    logic [3:0]       lat_cmd;
    logic [3:0]       lat_ahi;
    logic             cpl_fail;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_seen <= '0;
            rd_seen <= '0;
            lat_rd  <= 1'b0;
            lat_len <= '0;
            lat_cmd <= '0;
            lat_ahi <= '0;
        end else if (req_valid && req_ready) begin
            tx_seen <= '0;
            rd_seen <= '0;
            lat_rd  <= req_cmd[0];
            lat_len <= req_len;
            lat_cmd <= req_cmd;
            lat_ahi <= req_addr[19:16];
        end else begin
            if (tx_valid && tx_ready) tx_seen <= tx_seen + 1'b1;
            if (rd_valid)             rd_seen <= rd_seen + 1'b1;
        end
    end

    assign cpl_fail = (cpl_err == 3'(CPL_TIMEOUT)) || (cpl_err == 3'(CPL_FLAGS)) ||
                      (cpl_err == 3'(CPL_LINK));

    assert_hdr_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_seen == 2) |-> (tx_data == {lat_cmd, lat_ahi}));

    assert_size_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_err == 3'(CPL_SIZE)) |-> (tx_seen == 0 && cpl_count == 0));

    assert_inval_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_err == 3'(CPL_INVAL)) |-> (tx_seen == 0 && cpl_count == 0));

    assert_fail_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_fail) |-> (cpl_count == 0 && cpl_reply == 0 && rd_seen == 0));

    assert_read_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_err == 3'(CPL_OK) && lat_rd) |->
        (rd_seen == {1'b0, cpl_count} && cpl_count <= lat_len));

    assert_write_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_err == 3'(CPL_OK) && !lat_rd) |->
        (cpl_count == lat_len && rd_seen == 0));

    assert_one_outstanding_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> !req_ready);

    assert_cpl_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !cpl_ready) |=>
        (cpl_valid && $stable(cpl_err) && $stable(cpl_count) && $stable(cpl_reply)));

endmodule

bind aux_req_framer aux_req_framer_chk #(.MAX_PAY(MAX_PAY), .LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_cmd   (req_cmd),
    .req_len   (req_len),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .rd_valid  (rd_valid),
    .cpl_valid (cpl_valid),
    .cpl_ready (cpl_ready),
    .cpl_err   (cpl_err),
    .cpl_count (cpl_count),
    .cpl_reply (cpl_reply)
);

// File: tb/aux_req_framer_tb.sv
module aux_req_framer_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [19:0] req_addr;
    logic [3:0]  req_cmd;
    logic [4:0]  req_len;
    logic        pay_valid;
    logic        pay_ready;
    logic [7:0]  pay_data;
    logic        tx_valid;
    logic        tx_ready;
    logic [7:0]  tx_data;
    logic        tx_last;
    logic        rx_hdr_valid;
    logic [7:0]  rx_status;
    logic [4:0]  rx_count;
    logic        rx_valid;
    logic [7:0]  rx_data;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        cpl_valid;
    logic        cpl_ready;
    logic [2:0]  cpl_err;
    logic [4:0]  cpl_count;
    logic [3:0]  cpl_reply;

    int compared   = 0;
    int mismatched = 0;
    int cpl_done   = 0;
    bit stall_en   = 0;
    bit pay_fire   = 0;

    logic [8:0]  exp_tx[$];
    string       tag_tx[$];
    logic [7:0]  exp_rd[$];
    string       tag_rd[$];
    logic [11:0] exp_cpl[$];
    string       tag_cpl[$];
    logic [7:0]  pay_q[$];
    logic [7:0]  rs_q[$];
    logic [4:0]  rc_q[$];
    logic [7:0]  rb_q[$];

    always #10 clk = ~clk;

    aux_req_framer u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_cmd(req_cmd), .req_len(req_len),
        .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_data(pay_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
        .rx_hdr_valid(rx_hdr_valid), .rx_status(rx_status), .rx_count(rx_count),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_err(cpl_err),
        .cpl_count(cpl_count), .cpl_reply(cpl_reply)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // outbound stream monitor (R1..R4)
    initial forever begin
        @(negedge clk); #2;
        if (rst_n && tx_valid && tx_ready) begin
            if (exp_tx.size() == 0) check("R4 unexpected tx byte", {23'd0, tx_last, tx_data}, 32'h1FF);
            else check(tag_tx.pop_front(), {23'd0, tx_last, tx_data}, {23'd0, exp_tx.pop_front()});
        end
    end

    // forwarded read byte monitor (R7, R8, R9)
    initial forever begin
        @(negedge clk); #2;
        if (rst_n && rd_valid) begin
            if (exp_rd.size() == 0) check("R8 unexpected read byte", {24'd0, rd_data}, 32'h100);
            else check(tag_rd.pop_front(), {24'd0, rd_data}, {24'd0, exp_rd.pop_front()});
        end
    end

    // completion monitor
    initial forever begin
        @(negedge clk); #2;
        if (rst_n && cpl_valid && cpl_ready) begin
            if (exp_cpl.size() == 0) check("R11 unexpected completion", {20'd0, cpl_err, cpl_count, cpl_reply}, 32'hFFF);
            else check(tag_cpl.pop_front(), {20'd0, cpl_err, cpl_count, cpl_reply}, {20'd0, exp_cpl.pop_front()});
            cpl_done++;
        end
    end

    // payload source
    initial begin
        pay_valid = 1'b0;
        pay_data  = 8'h00;
        forever begin
            @(negedge clk);
            if (pay_fire) void'(pay_q.pop_front());
            pay_valid = (pay_q.size() > 0);
            pay_data  = pay_valid ? pay_q[0] : 8'h00;
            #2 pay_fire = pay_valid && pay_ready;
        end
    end

    // engine back-pressure
    initial begin
        tx_ready = 1'b1;
        forever begin
            @(negedge clk);
            tx_ready = stall_en ? 1'($urandom_range(0, 1)) : 1'b1;
        end
    end

    // channel engine reply model
    initial begin
        rx_hdr_valid = 1'b0;
        rx_status    = 8'h00;
        rx_count     = 5'd0;
        rx_valid     = 1'b0;
        rx_data      = 8'h00;
        forever begin
            @(negedge clk); #2;
            if (rst_n && tx_valid && tx_ready && tx_last) begin
                logic [7:0] st;
                logic [4:0] n;
                st = rs_q.pop_front();
                n  = rc_q.pop_front();
                repeat (3) @(negedge clk);
                rx_status    = st;
                rx_count     = n;
                rx_hdr_valid = 1'b1;
                @(negedge clk);
                rx_hdr_valid = 1'b0;
                for (int k = 0; k < int'(n); k++) begin
                    rx_valid = 1'b1;
                    rx_data  = rb_q.pop_front();
                    @(negedge clk);
                end
                rx_valid = 1'b0;
            end
        end
    end

    // driver: pushes expectations, offers the request until accepted
    task automatic issue(string tag, logic [19:0] a, logic [3:0] c, int len, logic [7:0] st, int rxn);
        logic [3:0] base;
        bit         ok_cmd, wr, fail;
        logic [3:0] lo, hi;
        int         cnt;
        base   = c & 4'b1011;
        ok_cmd = (base == 4'h0) || (base == 4'h1) || (base == 4'h8) || (base == 4'h9);
        wr     = ~c[0];
        if (len > 16) begin
            exp_cpl.push_back({3'd1, 5'd0, 4'd0}); tag_cpl.push_back({tag, " R5 size error"});
        end else if (!ok_cmd) begin
            exp_cpl.push_back({3'd2, 5'd0, 4'd0}); tag_cpl.push_back({tag, " R6 invalid code"});
        end else begin
            lo = (len == 0) ? 4'd0 : 4'(len - 1);
            hi = (len == 0) ? 4'd3 : (wr ? 4'(4 + len) : 4'd4);
            exp_tx.push_back({1'b0, a[7:0]});  tag_tx.push_back({tag, " R1 byte0"});
            exp_tx.push_back({1'b0, a[15:8]}); tag_tx.push_back({tag, " R1 byte1"});
            exp_tx.push_back({1'b0, c, a[19:16]}); tag_tx.push_back({tag, " R1 byte2"});
            exp_tx.push_back({(wr && len > 0) ? 1'b0 : 1'b1, hi, lo}); tag_tx.push_back({tag, " R2 R3 byte3"});
            if (wr) for (int k = 0; k < len; k++) begin
                logic [7:0] b;
                b = 8'(a[7:0] + 8'(k * 7) + 8'd1);
                pay_q.push_back(b);
                exp_tx.push_back({(k == len - 1) ? 1'b1 : 1'b0, b}); tag_tx.push_back({tag, " R4 payload"});
            end
            rs_q.push_back(st);
            rc_q.push_back(5'(rxn));
            fail = (st == 8'd1) || (st == 8'd2) || (st == 8'd3);
            cnt  = wr ? len : ((rxn < len) ? rxn : len);
            for (int k = 0; k < rxn; k++) begin
                logic [7:0] b;
                b = 8'(8'hA0 ^ 8'(k * 3 + 1));
                rb_q.push_back(b);
                if (!fail && !wr && k < cnt) begin
                    exp_rd.push_back(b); tag_rd.push_back({tag, " R8 read byte"});
                end
            end
            if (fail) begin
                exp_cpl.push_back({3'(st + 8'd2), 5'd0, 4'd0}); tag_cpl.push_back({tag, " R7 reply failure"});
            end else begin
                exp_cpl.push_back({3'd0, 5'(cnt), st[7:4]});
                tag_cpl.push_back({tag, wr ? " R9 R10 write done" : " R8 R10 read done"});
            end
        end
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_cmd   = c;
        req_len   = 5'(len);
        #2;
        while (!req_ready) begin
            @(negedge clk); #2;
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic run_req(string tag, logic [19:0] a, logic [3:0] c, int len, logic [7:0] st, int rxn);
        int target;
        target = cpl_done + 1;
        issue(tag, a, c, len, st, rxn);
        while (cpl_done < target) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int target;
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_addr  = '0;
        req_cmd   = '0;
        req_len   = '0;
        cpl_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #2;
        check("R11 reset req_ready", {31'd0, req_ready}, 1);
        check("R11 reset tx_valid",  {31'd0, tx_valid},  0);
        check("R11 reset cpl_valid", {31'd0, cpl_valid}, 0);

        run_req("native write",      20'h12345, 4'h8, 3,  8'h00, 0);
        run_req("native read",       20'hABCDE, 4'h9, 4,  8'h00, 4);
        run_req("i2c read clamp",    20'h00050, 4'h5, 2,  8'h20, 5);
        run_req("bare i2c write",    20'h00077, 4'h4, 0,  8'h10, 0);
        run_req("bare native read",  20'hF0001, 4'h9, 0,  8'h00, 2);
        run_req("short reply read",  20'h31415, 4'h1, 6,  8'h00, 3);
        run_req("empty reply read",  20'h27182, 4'h9, 4,  8'h00, 0);
        stall_en = 1;
        run_req("max write stalled", 20'h5A5A5, 4'h0, 16, 8'h00, 0);
        run_req("max read stalled",  20'hC3C3C, 4'hD, 16, 8'h30, 16);
        stall_en = 0;
        run_req("len 17",            20'h11111, 4'h8, 17, 8'h00, 0);
        run_req("len 31 bad code",   20'h22222, 4'h2, 31, 8'h00, 0);
        run_req("code 2",            20'h33333, 4'h2, 1,  8'h00, 0);
        run_req("code A",            20'h44444, 4'hA, 1,  8'h00, 0);
        run_req("timeout read",      20'h55555, 4'h9, 3,  8'h01, 3);
        run_req("flags write",       20'h66666, 4'h8, 2,  8'h02, 0);
        run_req("link error read",   20'h77777, 4'h1, 1,  8'h03, 1);

        // completion pending while the next request is offered (R11)
        target    = cpl_done + 2;
        cpl_ready = 1'b0;
        issue("held A", 20'h0ABCD, 4'h8, 1, 8'h00, 0);
        #2;
        while (!cpl_valid) begin
            @(negedge clk); #2;
        end
        fork
            issue("held B", 20'h0DCBA, 4'h9, 2, 8'h00, 2);
        join_none
        repeat (3) begin
            @(negedge clk); #3;
            check("R11 no accept while completion pending", {31'd0, req_ready}, 0);
            check("R11 completion still valid",             {31'd0, cpl_valid}, 1);
        end
        @(negedge clk);
        cpl_ready = 1'b1;
        while (cpl_done < target) @(negedge clk);
        repeat (4) @(negedge clk);

        check("R4 no leftover tx",     exp_tx.size(),  0);
        check("R8 no leftover read",   exp_rd.size(),  0);
        check("R11 no leftover cpl",   exp_cpl.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule